// File: doc/BRIEF.md
# SPI Master with Per-Target Clock Configuration

This block is a memory-mapped SPI master. Software writes 8-bit words into a transmit register and reads received words from a receive register. The block shifts each word out on MOSI, most significant bit first, and shifts the reply in from MISO at the same time. Four chip-select outputs address up to four targets. Each target has its own configuration register, which holds its clock divisor, idle clock level and sampling phase. A new word can be written while the previous one is still shifting, so a polled loop can keep the link busy without gaps.

A mode register enables master operation and picks the target with a one-cold select field. The configuration of that target is applied at the start of each word. A status register reports four things: the transmit holding register is free, the whole transmitter is idle, a received word is waiting, and a received word was overwritten before it was read. An optional wait mode holds back the next word until the previous reply has been read, so no reply is ever lost.

Top module: `spi_select_master`

## Requirements
- R1: After reset, and after a write to offset 0x00 with bit 7 set (soft reset), these defaults apply: status (0x10) reads 0x0000_0202, mode (0x04) and every configuration register read 0, all `cs_n` lines are high, and `sck` is low.
- R2: A write to 0x00 with bit 0 set enables the block and one with bit 1 set disables it. If both bits are set, disable wins. Status bit 16 shows the enabled state. Words move only while the block is enabled and mode bit 0 (master) is set. A write to the transmit register (0x0C) while the block is not running is ignored, and status bit 1 stays 1.
- R3: Mode bits [19:16] form a one-cold select field, and the target is the lowest-numbered bit that is 0. While running, only that target's `cs_n` line is low. When the field is all ones, no line is low and no word starts.
- R4: Configuration register n is at 0x30+4n. Its bit 0 is the idle clock level, bit 1 is an inverted phase bit, and bits [15:8] are the divisor D. One SCK period lasts D clock cycles, and a D of 0 or 1 acts as 2. The configuration used is that of the selected target.
- R5: SCK rests at the idle level between words. When bit 1 is set, each data bit is driven before the leading edge and sampled on the leading edge. When bit 1 is clear, each bit is driven on the leading edge and sampled on the trailing edge. A word is 8 bits, MSB first, in both directions at once.
- R6: Status bit 1 is set while the transmit holding register is empty. A write to 0x0C fills the holding register and clears bit 1 until the word moves into the shifter. Words go out in the order they were written.
- R7: Status bit 9 is set only while the holding register is empty and no word is shifting.
- R8: The received word appears in the receive register (0x08, bits [7:0]) and sets status bit 0 at the (8·D+2)-th rising edge after the edge that accepted the write into an idle transmitter.
- R9: If a word completes while status bit 0 is already set, status bit 3 (overrun) is set, and the new word replaces the old one.
- R10: Reading 0x08 clears status bits 0 and 3.
- R11: While mode bit 5 (wait mode) is set, no word starts while status bit 0 is set.
- R12: When a read of 0x08 falls in the same cycle as the loading of a new word, the load wins. The read returns the old word, bit 0 stays set, and bit 3 is clear afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
Two functions can act on the receive flags in the same cycle: software reading the receive register, and the shifter delivering a finished word. The bench first leaves one reply unread. It then starts a new word and places a single-cycle read strobe on the exact edge where, by the R8 latency, the new word loads. It then checks three things: the read returned the old word, the full flag is still set and overrun is clear, and the next read returns the new word. A read one cycle late would instead leave overrun set and then clear the full flag, so a wrong priority between the two shows up.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DIVW = 8;

  typedef struct packed {
    logic [DIVW-1:0] div;
    logic            ncpha;
    logic            cpol;
  } cs_cfg_t;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_MODE = 'h04;
  localparam int OFF_RXD  = 'h08;
  localparam int OFF_TXD  = 'h0C;
  localparam int OFF_STAT = 'h10;
  localparam int OFF_CFG0 = 'h30;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_DIS  = 1;
  localparam int CTRL_SRST = 7;

  localparam int MODE_MSTR = 0;
  localparam int MODE_MFD  = 4;
  localparam int MODE_WFR  = 5;
  localparam int MODE_SEL  = 16;

  localparam int ST_RXF  = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_OVR  = 3;
  localparam int ST_IDLE = 9;
  localparam int ST_EN   = 16;

  // Divisor used for the SCK period: anything below 2 runs at 2.
  function automatic logic [DIVW-1:0] clamp_div(input logic [DIVW-1:0] d);
    return (d < DIVW'(2)) ? DIVW'(2) : d;
  endfunction
endpackage

// File: rtl/spim_cfg_bank.sv
module spim_cfg_bank
  import spim_pkg::*;
#(
  parameter int NCS    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output cs_cfg_t           cfg_q [NCS]
);
  for (genvar i = 0; i < NCS; i++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(OFF_CFG0 + 4 * i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[i] <= '0;
      else if (clr)
        cfg_q[i] <= '0;
      else if (wr_en && addr == MY_OFF)
        cfg_q[i] <= '{div: wdata[8 +: DIVW], ncpha: wdata[1], cpol: wdata[0]};
    end
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [DW-1:0] tx_word,
  input  cs_cfg_t       cfg,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_word
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic [DIVW-1:0] l_div, cnt, half;
  logic            l_cpol, l_cpha;
  logic [BW-1:0]   bitn;
  logic [DW-1:0]   sh_tx, sh_rx, rx_next;
  logic            lead_ev, trail_ev, sample_now, shift_now, last_bit;

  assign half       = l_div >> 1;
  assign lead_ev    = busy && (cnt == half - DIVW'(1));
  assign trail_ev   = busy && (cnt == l_div - DIVW'(1));
  assign last_bit   = (bitn == BW'(DW - 1));
  assign sample_now = l_cpha ? trail_ev : lead_ev;
  assign shift_now  = l_cpha ? lead_ev : trail_ev;
  assign rx_next    = {sh_rx[DW-2:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0; bitn <= '0;
      sh_tx <= '0; sh_rx <= '0; rx_word <= '0;
      sck <= 1'b0; mosi <= 1'b0;
      l_div <= DIVW'(2); l_cpol <= 1'b0; l_cpha <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        busy <= 1'b0;
        sck  <= cfg.cpol;
      end else if (!busy) begin
        sck <= cfg.cpol;
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          bitn   <= '0;
          l_div  <= clamp_div(cfg.div);
          l_cpol <= cfg.cpol;
          l_cpha <= ~cfg.ncpha;
          sh_tx  <= tx_word;
          if (cfg.ncpha) mosi <= tx_word[DW-1];
        end
      end else begin
        cnt <= trail_ev ? '0 : cnt + DIVW'(1);
        if (lead_ev)  sck <= ~l_cpol;
        if (trail_ev) sck <= l_cpol;
        if (sample_now) sh_rx <= rx_next;
        if (shift_now) begin
          if (l_cpha)         mosi <= sh_tx[DW-1];
          else if (!last_bit) mosi <= sh_tx[DW-2];
          sh_tx <= sh_tx << 1;
        end
        if (trail_ev) begin
          bitn <= bitn + BW'(1);
          if (last_bit) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_word <= l_cpha ? rx_next : sh_rx;
          end
        end
      end
    end
  end

  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cfg.cpol)) |-> (sck == cfg.cpol)) // R5
    else $error("sck not at idle level");
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)) // R8
    else $error("done without a frame");
endmodule

// File: rtl/spi_select_master.sv
module spi_select_master
  import spim_pkg::*;
#(
  parameter int NCS    = 4,
  parameter int DW     = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n
);
  localparam int SW = (NCS > 1) ? $clog2(NCS) : 1;

  function automatic logic [SW-1:0] lowest_zero(input logic [NCS-1:0] s);
    logic [SW-1:0] r;
    r = '0;
    for (int i = NCS - 1; i >= 0; i--)
      if (!s[i]) r = SW'(i);
    return r;
  endfunction

  logic          en, master, mfd, wfr;
  logic [NCS-1:0] sel;
  logic [DW-1:0] hold, rxd, rx_word;
  logic          hold_full, rx_full, ovr;
  logic          busy, done, start, run, sel_ok, soft_rst, sh_clr;
  logic [SW-1:0] tgt;
  cs_cfg_t       cfg_q [NCS];
  cs_cfg_t       cfg_sel;
  logic [31:0]   stat_word, rd_word;

  wire wr_ctrl = bus_wr && bus_addr == ADDR_W'(OFF_CTRL);
  wire wr_mode = bus_wr && bus_addr == ADDR_W'(OFF_MODE);
  wire wr_tx   = bus_wr && bus_addr == ADDR_W'(OFF_TXD);
  wire rd_rx   = bus_rd && bus_addr == ADDR_W'(OFF_RXD);

  assign soft_rst = wr_ctrl && bus_wdata[CTRL_SRST];
  assign run      = en && master;
  assign sel_ok   = ~&sel;
  assign tgt      = lowest_zero(sel);
  assign cfg_sel  = cfg_q[tgt];
  assign sh_clr   = soft_rst || !run;
  assign start    = run && sel_ok && hold_full && !busy && !done && !(wfr && rx_full);
  assign cs_n     = (run && sel_ok) ? ~(NCS'(1) << tgt) : '1;

  spim_cfg_bank #(.NCS(NCS), .ADDR_W(ADDR_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wr_en(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata[15:0]), .cfg_q(cfg_q));

  spim_shifter #(.DW(DW)) shf_i (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .start(start), .tx_word(hold),
    .cfg(cfg_sel), .miso(miso), .sck(sck), .mosi(mosi), .busy(busy),
    .done(done), .rx_word(rx_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; master <= 1'b0; mfd <= 1'b0; wfr <= 1'b0; sel <= '0;
      hold <= '0; hold_full <= 1'b0; rxd <= '0; rx_full <= 1'b0; ovr <= 1'b0;
    end else if (soft_rst) begin
      en <= 1'b0; master <= 1'b0; mfd <= 1'b0; wfr <= 1'b0; sel <= '0;
      hold <= '0; hold_full <= 1'b0; rxd <= '0; rx_full <= 1'b0; ovr <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        if (bus_wdata[CTRL_DIS])     en <= 1'b0;
        else if (bus_wdata[CTRL_EN]) en <= 1'b1;
      end
      if (wr_mode) begin
        master <= bus_wdata[MODE_MSTR];
        mfd    <= bus_wdata[MODE_MFD];
        wfr    <= bus_wdata[MODE_WFR];
        sel    <= bus_wdata[MODE_SEL +: NCS];
      end
      if (!run)                      hold_full <= 1'b0;
      else if (start)                hold_full <= 1'b0;
      else if (wr_tx && !hold_full) begin
        hold      <= bus_wdata[DW-1:0];
        hold_full <= 1'b1;
      end
      if (done) begin
        rxd     <= rx_word;
        rx_full <= 1'b1;
        ovr     <= rx_full && !rd_rx;
      end else if (rd_rx) begin
        rx_full <= 1'b0;
        ovr     <= 1'b0;
      end
    end
  end

  always_comb begin
    stat_word          = '0;
    stat_word[ST_RXF]  = rx_full;
    stat_word[ST_TXE]  = !hold_full;
    stat_word[ST_OVR]  = ovr;
    stat_word[ST_IDLE] = !hold_full && !busy;
    stat_word[ST_EN]   = en;
    rd_word = '0;
    if (bus_addr == ADDR_W'(OFF_MODE)) begin
      rd_word[MODE_MSTR]          = master;
      rd_word[MODE_MFD]           = mfd;
      rd_word[MODE_WFR]           = wfr;
      rd_word[MODE_SEL +: NCS]    = sel;
    end else if (bus_addr == ADDR_W'(OFF_RXD)) begin
      rd_word[DW-1:0] = rxd;
    end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
      rd_word = stat_word;
    end
    for (int i = 0; i < NCS; i++)
      if (bus_addr == ADDR_W'(OFF_CFG0 + 4 * i))
        rd_word[15:0] = {cfg_q[i].div, 6'b0, cfg_q[i].ncpha, cfg_q[i].cpol};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  AST_START_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cs_n != '1)) // R3
    else $error("frame without a selected target");
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> rx_full) // R9
    else $error("overrun without full receive register");
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !done && !soft_rst) |=> (!rx_full && !ovr)) // R10
    else $error("receive read did not clear flags");
  AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wfr && rx_full)) // R11
    else $error("frame started with unread data in wait mode");
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_rx && !soft_rst) |=> (rx_full && !ovr)) // R12
    else $error("read beat the load");
endmodule

// File: tb/spi_select_master_tb_top.sv
module spi_select_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso_r = 1'b0;
  logic [3:0] cs_n;

  always #10 clk = ~clk;

  spi_select_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso_r), .cs_n(cs_n));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc++;

  function automatic int exp_div(input int d);
    return (d < 2) ? 2 : d;
  endfunction
  function automatic logic [3:0] exp_cs(input logic [3:0] s);
    for (int i = 0; i < 4; i++) if (!s[i]) return ~(4'b1 << i);
    return 4'hF;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask
  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 3000; k++) begin
      rd(8'h10, s);
      if (s[9]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  // target model: samples and drives on the edges the selected mode defines
  logic s_arm = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0, s_prev = 1'b0;
  logic [7:0] s_tx, s_next, s_rx;
  logic [7:0] s_hist [4];
  int s_idx, s_ns, s_lead, s_t1, s_per;

  task automatic s_start(input logic cpol, input logic cpha, input logic [7:0] b0, input logic [7:0] b1);
    s_cpol = cpol; s_cpha = cpha; s_tx = b0; s_next = b1;
    s_idx = cpha ? -1 : 0; miso_r = cpha ? 1'b0 : b0[7];
    s_ns = 0; s_lead = 0; s_per = 0; s_prev = cpol;
    for (int k = 0; k < 4; k++) s_hist[k] = 8'h00;
    s_arm = 1'b1;
  endtask
  task automatic s_sample();
    s_rx = {s_rx[6:0], mosi};
    s_ns++;
    if (s_ns % 8 == 0 && s_ns <= 32) s_hist[s_ns/8 - 1] = s_rx;
  endtask

  always @(negedge clk) begin
    if (s_arm && sck !== s_prev) begin
      s_prev = sck;
      if (sck != s_cpol) begin
        s_lead++;
        if (s_lead == 1) s_t1 = cyc;
        if (s_lead == 2) s_per = cyc - s_t1;
        if (!s_cpha) s_sample();
        else begin s_idx++; miso_r = s_tx[7 - s_idx]; end
      end else begin
        if (!s_cpha) begin
          s_idx++;
          if (s_idx == 8) begin s_idx = 0; s_tx = s_next; end
          miso_r = s_tx[7 - s_idx];
        end else begin
          s_sample();
          if (s_ns % 8 == 0) begin s_idx = -1; s_tx = s_next; end
        end
      end
    end
  end

  task automatic do_frame(input int cs, input logic cpol, input logic cpha, input int div,
                          input logic [7:0] tx, input logic [7:0] sb);
    logic [31:0] d;
    wr(8'h30 + 8'(4 * cs), (32'(div) << 8) | (32'(!cpha) << 1) | 32'(cpol));
    wr(8'h04, 32'h1 | (32'(~(4'b1 << cs)) << 16));
    repeat (2) @(negedge clk);
    check("R5", "idle sck level", 32'(sck), 32'(cpol));
    s_start(cpol, cpha, sb, sb);
    wr(8'h0C, 32'(tx));
    check("R3", "selected cs_n", 32'(cs_n), 32'(exp_cs(~(4'b1 << cs))));
    wait_idle();
    s_arm = 1'b0;
    check("R5", "byte seen by target", 32'(s_hist[0]), 32'(tx));
    check("R4", "sck period", 32'(s_per), 32'(exp_div(div)));
    rd(8'h08, d);
    check("R8", "received byte", d, 32'(sb));
    rd(8'h10, d);
    check("R10", "full flag after read", 32'(d[0]), 32'd0);
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0] a, b;
    int dv;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset cs_n", 32'(cs_n), 32'hF);
    check("R1", "reset sck", 32'(sck), 32'd0);
    rd(8'h10, d); check("R1", "reset status", d, 32'h0000_0202);
    rd(8'h04, d); check("R1", "reset mode", d, 32'h0);

    // R2: enable/disable commands and writes while stopped
    wr(8'h04, 32'h000E_0001);
    wr(8'h0C, 32'h55);
    rd(8'h10, d); check("R2", "tx write ignored while disabled", 32'(d[1]), 32'd1);
    wr(8'h00, 32'h1);
    rd(8'h10, d); check("R2", "enabled flag", 32'(d[16]), 32'd1);
    wr(8'h00, 32'h3);
    rd(8'h10, d); check("R2", "disable wins", 32'(d[16]), 32'd0);
    wr(8'h00, 32'h1);

    // R4/R5 random modes, divisors and targets
    for (int it = 0; it < 12; it++) begin
      do_frame($urandom % 4, 1'($urandom), 1'($urandom), 2 + ($urandom % 6),
               8'($urandom), 8'($urandom));
    end
    // R4: divisor 0 runs at 2
    do_frame(2, 1'b0, 1'b1, 0, 8'hA5, 8'h3C);

    // R3: several zeros pick the lowest, all ones blocks
    wr(8'h04, 32'h0005_0001);
    @(negedge clk);
    check("R3", "lowest zero wins", 32'(cs_n), 32'(exp_cs(4'b0101)));
    wr(8'h30, 32'h0000_0402);
    wr(8'h04, 32'h000F_0001);
    @(negedge clk);
    check("R3", "all-ones select", 32'(cs_n), 32'hF);
    wr(8'h0C, 32'h81);
    repeat (60) @(negedge clk);
    rd(8'h10, d);
    check("R3", "no start without target", {d[9], d[1]}, 32'd0);
    s_start(1'b0, 1'b0, 8'h66, 8'h66);
    wr(8'h04, 32'h000E_0001);
    wait_idle(); s_arm = 1'b0;
    rd(8'h08, d); check("R3", "held word leaves after select", d, 32'h66);

    // R6/R9/R10: back-to-back words with no read
    a = 8'($urandom); b = 8'($urandom);
    s_start(1'b0, 1'b0, a, b);
    wr(8'h0C, 32'h12);
    wr(8'h0C, 32'h34);
    rd(8'h10, d);
    check("R6", "holding full", 32'(d[1]), 32'd0);
    check("R7", "not idle while holding", 32'(d[9]), 32'd0);
    wait_idle(); s_arm = 1'b0;
    check("R6", "first word order", 32'(s_hist[0]), 32'h12);
    check("R6", "second word order", 32'(s_hist[1]), 32'h34);
    rd(8'h10, d);
    check("R9", "overrun and full", {d[3], d[0]}, 32'h3);
    check("R7", "idle after both", 32'(d[9]), 32'd1);
    rd(8'h08, d); check("R9", "newest word kept", d, 32'(b));
    rd(8'h10, d); check("R10", "read clears both", {d[3], d[0]}, 32'd0);

    // R11: wait mode stalls the second word
    a = 8'($urandom); b = 8'($urandom);
    s_start(1'b0, 1'b0, a, b);
    wr(8'h04, 32'h000E_0021);
    wr(8'h0C, 32'h9A);
    wait_idle();
    wr(8'h0C, 32'hBC);
    repeat (100) @(negedge clk);
    rd(8'h10, d);
    check("R11", "stalled flags", {d[9], d[3], d[1], d[0]}, 32'h1);
    rd(8'h08, d); check("R11", "first reply", d, 32'(a));
    wait_idle(); s_arm = 1'b0;
    rd(8'h08, d); check("R11", "second reply", d, 32'(b));
    check("R11", "target saw second word", 32'(s_hist[1]), 32'hBC);

    // R12 and R8: read lands on the load edge
    wr(8'h04, 32'h000E_0001);
    dv = 3;
    wr(8'h30, 32'(dv) << 8 | 32'h2);
    a = 8'($urandom); b = 8'($urandom);
    s_start(1'b0, 1'b0, a, a);
    wr(8'h0C, 32'h11);
    wait_idle(); s_arm = 1'b0;
    s_start(1'b0, 1'b0, b, b);
    wr(8'h0C, 32'h22);
    repeat (8 * dv + 1) @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'h08;
    @(negedge clk); bus_rd = 1'b0;
    check("R12", "read returns old word", bus_rdata, 32'(a));
    repeat (3) @(negedge clk); s_arm = 1'b0;
    rd(8'h10, d);
    check("R12", "load wins over read", {d[3], d[0]}, 32'h1);
    rd(8'h08, d); check("R8", "new word after collision", d, 32'(b));

    // R2: disable drops select and ignores writes
    wr(8'h00, 32'h2);
    @(negedge clk);
    check("R2", "cs released when disabled", 32'(cs_n), 32'hF);
    wr(8'h0C, 32'h77);
    rd(8'h10, d); check("R2", "disabled status", {d[16], d[1]}, 32'h1);

    // R1: soft reset
    wr(8'h00, 32'h1);
    wr(8'h04, 32'h0021_0031);
    wr(8'h00, 32'h80);
    rd(8'h04, d); check("R1", "mode after soft reset", d, 32'h0);
    rd(8'h30, d); check("R1", "cfg after soft reset", d, 32'h0);
    rd(8'h10, d); check("R1", "status after soft reset", d, 32'h0000_0202);
    check("R1", "cs after soft reset", 32'(cs_n), 32'hF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule